// File: doc/BRIEF.md
# ATA Taskfile Load and Readback Sequencer

This block turns one ATA command into the ordered series of single-byte register accesses that a host adapter must perform on a drive's register set. For a load operation it latches a 16-bit feature word, a 16-bit sector count, a 48-bit block address, a unit select bit and an opcode, writes the taskfile registers, and writes the command register last. For a readback operation it reads the taskfile registers and reassembles the returned count and block address. Both operations come in a 28-bit variant, where each register is touched once, and a 48-bit variant, where each register is a two-deep stack written high byte first and read back by switching the high-order-byte select bit in the device control register.

Every register access is one transfer on a valid/ready port. An access stays on the port until `reg_ready_i` is seen high; read data is taken in the same cycle. An operation is accepted when `op_valid_i` is high and the block is idle. The electrical bus timing toward the drive and any data-phase transfer belong to the adapter on the far side of the port.

Top module: `ata_tf_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `reg_valid_o` are low and `res_count_o` and `res_lba_o` are zero.
- R2: A 48-bit load writes, in this order: address 1 (feature) feat[15:8] then feat[7:0]; address 2 (count) cnt[15:8] then cnt[7:0]; address 3 (sector) lba[31:24] then lba[7:0]; address 4 (cylinder low) lba[39:32] then lba[15:8]; address 5 (cylinder high) lba[47:40] then lba[23:16]; then address 6 (drive/head); then address 7 (command).
- R3: A 28-bit load writes each of addresses 1 to 5 once with feat[7:0], cnt[7:0], lba[7:0], lba[15:8], lba[23:16], then address 6 with 0xE0 | unit<<4 | lba[27:24], then the command.
- R4: In a 48-bit load the drive/head byte is 0x40 | unit<<4; no address bits enter it.
- R5: The command register (address 7) is written only by a load, with the opcode, and only as the last access after all taskfile writes; `busy_o` falls right after it completes.
- R6: A 48-bit readback writes 0x88 to the control register (address 14), reads addresses 2,3,4,5 as cnt[15:8], lba[31:24], lba[39:32], lba[47:40], writes 0x08 to address 14, then reads addresses 2,3,4,5 as cnt[7:0], lba[7:0], lba[15:8], lba[23:16].
- R7: A 28-bit readback reads addresses 2,3,4,5,6; the result count is {8'h00, byte}, lba[27:24] is the low nibble of the drive/head byte, and lba[47:28] is zero.
- R8: While `reg_ready_i` is low the presented access (valid, write flag, address, data) is held unchanged; the sequence advances only on a completed transfer.
- R9: `busy_o` rises the cycle after acceptance and stays high until the final access completes (12, 7, 10 and 5 cycles for 48-bit load, 28-bit load, 48-bit readback and 28-bit readback with no stalls); `done_o` pulses for one cycle as `busy_o` falls; `op_valid_i` and operand inputs are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Request a new operation |
| op_rdbk_i | input | 1 | 1 = readback, 0 = load |
| op_ext_i | input | 1 | 1 = 48-bit addressing, 0 = 28-bit |
| feat_i | input | 16 | Feature word |
| count_i | input | 16 | Sector count |
| lba_i | input | 48 | Block address |
| unit_i | input | 1 | Unit select |
| cmd_i | input | 8 | Command opcode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reg_valid_o | output | 1 | Register access presented |
| reg_write_o | output | 1 | 1 = write access, 0 = read access |
| reg_addr_o | output | 4 | Register address |
| reg_wdata_o | output | 8 | Write data |
| reg_ready_i | input | 1 | Access completes this cycle |
| reg_rdata_i | input | 8 | Read data, valid with ready on a read |
| res_count_o | output | 16 | Reassembled count from readback |
| res_lba_o | output | 48 | Reassembled block address from readback |

## Verification
The assertions take for granted that `reg_ready_i` may follow any pattern and that `reg_rdata_i` is meaningful only in a cycle where a read completes; they also rely on operands mattering only in the accepting cycle. The stimulus drives ready and read data half a cycle before the edge, once with ready always high and once with ready high only every third cycle, and returns read bytes from a small drive model that answers with the high-order bytes whenever the last control write had bit 7 set. A second request with different operands is raised in the middle of a busy operation to show it leaves both the access sequence and the results untouched.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  localparam logic [ADDR_W-1:0] A_FEAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CLO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CHI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DRV  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMD  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd14;

  localparam logic [DATA_W-1:0] CTRL_IEN  = 8'h08;
  localparam logic [DATA_W-1:0] CTRL_HOB  = 8'h80;
  localparam logic [DATA_W-1:0] DRV_LBA   = 8'h40;
  localparam logic [DATA_W-1:0] DRV_FIXED = 8'hA0;

  typedef enum logic [3:0] {
    DST_NONE, DST_CNT_HI, DST_CNT_LO,
    DST_L0, DST_L1, DST_L2, DST_L3, DST_L4, DST_L5, DST_NIB
  } dst_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DATA_W-1:0] data;
    dst_e              dst;
  } step_t;

  function automatic logic [IDX_W-1:0] step_total(logic load, logic ext);
    if (load) return ext ? IDX_W'(12) : IDX_W'(7);
    return ext ? IDX_W'(10) : IDX_W'(5);
  endfunction

  function automatic logic [DATA_W-1:0] drive_byte(logic ext, logic unit,
                                                   logic [3:0] nib);
    if (ext) return DRV_LBA | {3'b000, unit, 4'h0};
    return DRV_FIXED | DRV_LBA | {3'b000, unit, nib};
  endfunction

  function automatic step_t wr_step(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step_t s;
    s = '0;
    s.addr = a;
    s.wr   = 1'b1;
    s.data = d;
    s.dst  = DST_NONE;
    return s;
  endfunction

  function automatic step_t rd_step(logic [ADDR_W-1:0] a, dst_e d);
    step_t s;
    s = '0;
    s.addr = a;
    s.wr   = 1'b0;
    s.dst  = d;
    return s;
  endfunction

endpackage

// File: rtl/ata_tf_steps.sv
module ata_tf_steps
  import ata_tf_pkg::*;
(
  input  logic             load_i,
  input  logic             ext_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      feat_i,
  input  logic [15:0]      count_i,
  input  logic [47:0]      lba_i,
  input  logic             unit_i,
  input  logic [7:0]       cmd_i,
  output step_t            step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] total_o
);

  assign total_o = step_total(load_i, ext_i);
  assign last_o  = (idx_i == total_o - IDX_W'(1));

  always_comb begin
    step_o = wr_step(A_CMD, cmd_i);
    case ({load_i, ext_i})
      2'b11: begin
        case (idx_i)
          4'd0:  step_o = wr_step(A_FEAT, feat_i[15:8]);
          4'd1:  step_o = wr_step(A_FEAT, feat_i[7:0]);
          4'd2:  step_o = wr_step(A_CNT,  count_i[15:8]);
          4'd3:  step_o = wr_step(A_CNT,  count_i[7:0]);
          4'd4:  step_o = wr_step(A_SEC,  lba_i[31:24]);
          4'd5:  step_o = wr_step(A_SEC,  lba_i[7:0]);
          4'd6:  step_o = wr_step(A_CLO,  lba_i[39:32]);
          4'd7:  step_o = wr_step(A_CLO,  lba_i[15:8]);
          4'd8:  step_o = wr_step(A_CHI,  lba_i[47:40]);
          4'd9:  step_o = wr_step(A_CHI,  lba_i[23:16]);
          4'd10: step_o = wr_step(A_DRV,  drive_byte(1'b1, unit_i, 4'h0));
          default: step_o = wr_step(A_CMD, cmd_i);
        endcase
      end
      2'b10: begin
        case (idx_i)
          4'd0: step_o = wr_step(A_FEAT, feat_i[7:0]);
          4'd1: step_o = wr_step(A_CNT,  count_i[7:0]);
          4'd2: step_o = wr_step(A_SEC,  lba_i[7:0]);
          4'd3: step_o = wr_step(A_CLO,  lba_i[15:8]);
          4'd4: step_o = wr_step(A_CHI,  lba_i[23:16]);
          4'd5: step_o = wr_step(A_DRV,  drive_byte(1'b0, unit_i, lba_i[27:24]));
          default: step_o = wr_step(A_CMD, cmd_i);
        endcase
      end
      2'b01: begin
        case (idx_i)
          4'd0: step_o = wr_step(A_CTRL, CTRL_IEN | CTRL_HOB);
          4'd1: step_o = rd_step(A_CNT, DST_CNT_HI);
          4'd2: step_o = rd_step(A_SEC, DST_L3);
          4'd3: step_o = rd_step(A_CLO, DST_L4);
          4'd4: step_o = rd_step(A_CHI, DST_L5);
          4'd5: step_o = wr_step(A_CTRL, CTRL_IEN);
          4'd6: step_o = rd_step(A_CNT, DST_CNT_LO);
          4'd7: step_o = rd_step(A_SEC, DST_L0);
          4'd8: step_o = rd_step(A_CLO, DST_L1);
          default: step_o = rd_step(A_CHI, DST_L2);
        endcase
      end
      default: begin
        case (idx_i)
          4'd0: step_o = rd_step(A_CNT, DST_CNT_LO);
          4'd1: step_o = rd_step(A_SEC, DST_L0);
          4'd2: step_o = rd_step(A_CLO, DST_L1);
          4'd3: step_o = rd_step(A_CHI, DST_L2);
          default: step_o = rd_step(A_DRV, DST_NIB);
        endcase
      end
    endcase
  end

endmodule

// File: rtl/ata_tf_gather.sv
module ata_tf_gather
  import ata_tf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        cap_i,
  input  dst_e        dst_i,
  input  logic [7:0]  rdata_i,
  output logic [15:0] count_o,
  output logic [47:0] lba_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      count_o <= '0;
      lba_o   <= '0;
    end else if (cap_i) begin
      case (dst_i)
        DST_CNT_HI: count_o[15:8]  <= rdata_i;
        DST_CNT_LO: count_o[7:0]   <= rdata_i;
        DST_L0:     lba_o[7:0]     <= rdata_i;
        DST_L1:     lba_o[15:8]    <= rdata_i;
        DST_L2:     lba_o[23:16]   <= rdata_i;
        DST_L3:     lba_o[31:24]   <= rdata_i;
        DST_L4:     lba_o[39:32]   <= rdata_i;
        DST_L5:     lba_o[47:40]   <= rdata_i;
        DST_NIB:    lba_o[27:24]   <= rdata_i[3:0];
        default: ;
      endcase
    end
  end

  // R7: the drive/head nibble only lands in bits 27:24, upper bits stay clear
  p_nib_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i && dst_i == DST_NIB && !clear_i |=> lba_o[31:28] == $past(lba_o[31:28]));

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid_i,
  input  logic        op_rdbk_i,
  input  logic        op_ext_i,
  input  logic [15:0] feat_i,
  input  logic [15:0] count_i,
  input  logic [47:0] lba_i,
  input  logic        unit_i,
  input  logic [7:0]  cmd_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        reg_valid_o,
  output logic        reg_write_o,
  output logic [3:0]  reg_addr_o,
  output logic [7:0]  reg_wdata_o,
  input  logic        reg_ready_i,
  input  logic [7:0]  reg_rdata_i,
  output logic [15:0] res_count_o,
  output logic [47:0] res_lba_o
);

  logic             busy_q, done_q, load_q, ext_q, unit_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      feat_q, count_q;
  logic [47:0]      lba_q;
  logic [7:0]       cmd_q;

  step_t            cur_step;
  logic             cur_last;
  logic [IDX_W-1:0] cur_total;

  // named events for the assertions
  logic op_accept, acc_fire, rd_fire;
  assign op_accept = op_valid_i && !busy_q;
  assign acc_fire  = busy_q && reg_ready_i;
  assign rd_fire   = acc_fire && !cur_step.wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      load_q  <= 1'b0;
      ext_q   <= 1'b0;
      unit_q  <= 1'b0;
      feat_q  <= '0;
      count_q <= '0;
      lba_q   <= '0;
      cmd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (op_accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        load_q  <= !op_rdbk_i;
        ext_q   <= op_ext_i;
        unit_q  <= unit_i;
        feat_q  <= feat_i;
        count_q <= count_i;
        lba_q   <= lba_i;
        cmd_q   <= cmd_i;
      end else if (acc_fire) begin
        if (cur_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  ata_tf_steps u_steps (
    .load_i  (load_q),
    .ext_i   (ext_q),
    .idx_i   (idx_q),
    .feat_i  (feat_q),
    .count_i (count_q),
    .lba_i   (lba_q),
    .unit_i  (unit_q),
    .cmd_i   (cmd_q),
    .step_o  (cur_step),
    .last_o  (cur_last),
    .total_o (cur_total)
  );

  ata_tf_gather u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (op_accept),
    .cap_i   (rd_fire),
    .dst_i   (cur_step.dst),
    .rdata_i (reg_rdata_i),
    .count_o (res_count_o),
    .lba_o   (res_lba_o)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign reg_valid_o = busy_q;
  assign reg_write_o = cur_step.wr;
  assign reg_addr_o  = cur_step.addr;
  assign reg_wdata_o = cur_step.wr ? cur_step.data : 8'h00;

  // R8: a stalled access is held unchanged
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid_o && !reg_ready_i |=> reg_valid_o && $stable(reg_addr_o)
      && $stable(reg_wdata_o) && $stable(reg_write_o));

  // R5: completing the command write ends the operation
  p_cmd_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && reg_addr_o == A_CMD |=> !busy_o);

  // R5: the command register is only ever written, and only by a load
  p_cmd_write_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid_o && reg_addr_o == A_CMD |-> reg_write_o && load_q);

  // R6: the control register is touched only by a 48-bit readback
  p_ctrl_rdbk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid_o && reg_addr_o == A_CTRL |-> !load_q && ext_q && reg_write_o);

  // R9: the completion pulse coincides with the fall of busy
  p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  // R9: the step counter stays inside the selected sequence
  p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> idx_q < cur_total);

endmodule

// File: tb/ata_tf_seq_tb_top.sv
module ata_tf_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid_i = 1'b0, op_rdbk_i = 1'b0, op_ext_i = 1'b0;
  logic [15:0] feat_i = '0, count_i = '0;
  logic [47:0] lba_i = '0;
  logic        unit_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic        busy_o, done_o, reg_valid_o, reg_write_o;
  logic [3:0]  reg_addr_o;
  logic [7:0]  reg_wdata_o;
  logic        reg_ready_i = 1'b0;
  logic [7:0]  reg_rdata_i = '0;
  logic [15:0] res_count_o;
  logic [47:0] res_lba_o;

  always #4 clk = ~clk;

  ata_tf_seq dut_i (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // access log and expected list
  logic [3:0] log_a [0:31];
  logic       log_w [0:31];
  logic [7:0] log_d [0:31];
  int         log_n = 0;
  logic [3:0] exp_a [0:31];
  logic       exp_w [0:31];
  logic [7:0] exp_d [0:31];
  int         exp_n = 0;

  // drive model
  int  stall_mode = 0;
  int  stall_cnt  = 0;
  bit  hob = 0;
  logic [7:0] dv_lo [0:7];
  logic [7:0] dv_hi [0:7];

  always @(negedge clk) begin
    if (reg_valid_o) begin
      stall_cnt = stall_cnt + 1;
      if (stall_mode == 0 || (stall_cnt % 3) == 0) begin
        reg_ready_i <= 1'b1;
        reg_rdata_i <= hob ? dv_hi[reg_addr_o[2:0]] : dv_lo[reg_addr_o[2:0]];
        if (log_n < 32) begin
          log_a[log_n] = reg_addr_o;
          log_w[log_n] = reg_write_o;
          log_d[log_n] = reg_wdata_o;
          log_n = log_n + 1;
        end
        if (reg_write_o && reg_addr_o == 4'd14) hob = reg_wdata_o[7];
      end else begin
        reg_ready_i <= 1'b0;
        reg_rdata_i <= 8'hEE;
      end
    end else begin
      reg_ready_i <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] a, input logic w, input logic [7:0] d);
    exp_a[exp_n] = a; exp_w[exp_n] = w; exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic compare_log(input string req);
    bit ok;
    check(log_n == exp_n, req, "access count", 64'(log_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      ok = log_a[i] == exp_a[i] && log_w[i] == exp_w[i] &&
           (!exp_w[i] || log_d[i] == exp_d[i]);
      check(ok, req, $sformatf("access %0d {addr,wr,data}", i),
            {51'd0, log_a[i], log_w[i], log_d[i]},
            {51'd0, exp_a[i], exp_w[i], exp_d[i]});
    end
  endtask

  task automatic run_op(input bit rdbk, input bit ext, input logic [15:0] f,
                        input logic [15:0] c, input logic [47:0] l,
                        input bit u, input logic [7:0] cmd,
                        input bit inject, output int busy_cyc, output int dones);
    log_n = 0; busy_cyc = 0; dones = 0; stall_cnt = 0;
    @(negedge clk);
    op_valid_i = 1'b1; op_rdbk_i = rdbk; op_ext_i = ext;
    feat_i = f; count_i = c; lba_i = l; unit_i = u; cmd_i = cmd;
    @(negedge clk);
    op_valid_i = 1'b0;
    while (busy_o) begin
      busy_cyc++;
      if (inject && busy_cyc == 3) begin
        op_valid_i = 1'b1; op_rdbk_i = !rdbk; op_ext_i = !ext;
        feat_i = ~f; count_i = ~c; lba_i = ~l; unit_i = !u; cmd_i = ~cmd;
      end
      @(negedge clk);
      op_valid_i = 1'b0;
      if (done_o) dones++;
    end
    repeat (3) begin
      @(negedge clk);
      if (done_o) dones++;
    end
  endtask

  task automatic t_reset;
    check(!busy_o && !done_o && !reg_valid_o, "R1", "busy/done/valid",
          {61'd0, busy_o, done_o, reg_valid_o}, 64'd0);
    check(res_count_o == 0 && res_lba_o == 0, "R1", "results",
          {res_count_o, res_lba_o}, 64'd0);
  endtask

  task automatic t_load48(input int smode, input bit u);
    int bc, dn;
    logic [15:0] f = 16'hA1B2; logic [15:0] c = 16'hC3D4;
    logic [47:0] l = 48'h112233445566; logic [7:0] cmd = 8'h25;
    stall_mode = smode;
    run_op(0, 1, f, c, l, u, cmd, 0, bc, dn);
    exp_n = 0;
    push(1, 1, 8'hA1); push(1, 1, 8'hB2); push(2, 1, 8'hC3); push(2, 1, 8'hD4);
    push(3, 1, 8'h33); push(3, 1, 8'h66); push(4, 1, 8'h22); push(4, 1, 8'h55);
    push(5, 1, 8'h11); push(5, 1, 8'h44);
    push(6, 1, 8'h40 | (u ? 8'h10 : 8'h00));   // R4
    push(7, 1, cmd);                            // R5
    compare_log(smode ? "R2/R8" : "R2/R4/R5");
    if (smode == 0)
      check(bc == 12, "R9", "busy cycles 48-bit load", 64'(bc), 64'd12);
    else
      check(bc > 12, "R8", "stalls extend busy", 64'(bc), 64'd13);
    check(dn == 1, "R9", "done pulses", 64'(dn), 64'd1);
  endtask

  task automatic t_load28(input bit inject);
    int bc, dn;
    logic [47:0] l = 48'hFFFF_F9AB_CDEF; logic [7:0] cmd = 8'hC8;
    stall_mode = 0;
    run_op(0, 0, 16'h0F12, 16'h5534, l, 1'b1, cmd, inject, bc, dn);
    exp_n = 0;
    push(1, 1, 8'h12); push(2, 1, 8'h34); push(3, 1, 8'hEF); push(4, 1, 8'hCD);
    push(5, 1, 8'hAB);
    push(6, 1, 8'hE0 | 8'h10 | 8'h09);  // R3 drive byte
    push(7, 1, cmd);
    compare_log(inject ? "R9" : "R3/R5");
    check(bc == 7, "R9", "busy cycles 28-bit load", 64'(bc), 64'd7);
    check(dn == 1, inject ? "R9" : "R3", "done pulses", 64'(dn), 64'd1);
    check(!reg_valid_o && !busy_o, "R9", "idle after op",
          {62'd0, reg_valid_o, busy_o}, 64'd0);
  endtask

  task automatic t_rdbk48(input int smode);
    int bc, dn;
    stall_mode = smode; hob = 0;
    dv_hi[2] = 8'h9C; dv_hi[3] = 8'h7A; dv_hi[4] = 8'h8B; dv_hi[5] = 8'h6F;
    dv_lo[2] = 8'h1C; dv_lo[3] = 8'h2A; dv_lo[4] = 8'h3B; dv_lo[5] = 8'h4F;
    run_op(1, 1, '0, '0, '0, 0, '0, 0, bc, dn);
    exp_n = 0;
    push(14, 1, 8'h88); push(2, 0, 0); push(3, 0, 0); push(4, 0, 0); push(5, 0, 0);
    push(14, 1, 8'h08); push(2, 0, 0); push(3, 0, 0); push(4, 0, 0); push(5, 0, 0);
    compare_log("R6");
    check(res_count_o == 16'h9C1C, "R6", "count", 64'(res_count_o), 64'h9C1C);
    check(res_lba_o == 48'h6F8B7A4F3B2A, "R6", "lba", 64'(res_lba_o), 64'h6F8B7A4F3B2A);
    if (smode == 0)
      check(bc == 10, "R9", "busy cycles 48-bit readback", 64'(bc), 64'd10);
  endtask

  task automatic t_rdbk28;
    int bc, dn;
    stall_mode = 0; hob = 0;
    dv_lo[2] = 8'h81; dv_lo[3] = 8'h92; dv_lo[4] = 8'hA3; dv_lo[5] = 8'hB4;
    dv_lo[6] = 8'hFD;
    run_op(1, 0, '0, '0, '0, 0, '0, 0, bc, dn);
    exp_n = 0;
    push(2, 0, 0); push(3, 0, 0); push(4, 0, 0); push(5, 0, 0); push(6, 0, 0);
    compare_log("R7");
    check(res_count_o == 16'h0081, "R7", "count", 64'(res_count_o), 64'h81);
    check(res_lba_o == 48'h00000DB4A392, "R7", "lba", 64'(res_lba_o), 64'h0DB4A392);
    check(bc == 5, "R9", "busy cycles 28-bit readback", 64'(bc), 64'd5);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin dv_lo[i] = 8'h00; dv_hi[i] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load48(0, 1'b1);
    t_load48(1, 1'b0);
    t_load28(0);
    t_load28(1);
    t_rdbk48(0);
    t_rdbk48(1);
    t_rdbk28;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule